// File: doc/BRIEF.md
# Infrared Carrier Generator with Transmit Indicator

This block produces the modulation carrier for an infrared remote-control transmitter and a matching active-low indicator drive. It runs on a reference clock at twice the oscillator rate. Every carrier therefore comes from a registered half-period counter and has a 50% duty cycle, including the undivided one. A software-written 3-bit select register picks one of six carrier ratios or a steady high level. A transmit-enable input gates the carrier onto the active-high transmit output. When the indicator pin is in output mode, it is pulled low in step with every burst.

The core is a four-state machine.
- IDLE: not transmitting.
- MARK: high half of a carrier period.
- SPACE: low half of a carrier period.
- STEADY: constant high level.

The transitions are as follows.
- IDLE to MARK or STEADY when enable rises, using the current selection.
- MARK to SPACE when the half-period count runs out.
- SPACE to MARK or STEADY at the period boundary, where a pending new selection is adopted.
- Any state to IDLE when enable is low.

The state register, the next-state logic and the output register are separate processes. Each output is a flop fed from the next state, so the outputs are free of glitches.

Top module: `ir_carrier_gen`

## Requirements
- R1: After reset, `rem_out` is 0, `led_n` is 1, `led_oe` is 0, and the select register holds 000.
- R2: With select code 000, 001, 010, 011, 100 or 101, the burst is a square wave whose high and low halves each last 1, 2, 8, 12, 16 or 24 reference cycles respectively.
- R3: Select codes 110 and 111 hold `rem_out` at 1 for as long as `tx_en` stays high.
- R4: When `tx_en` is sampled high in IDLE, `rem_out` goes high one cycle later and begins a full-length high half.
- R5: When `tx_en` is sampled low, `rem_out` is 0 from the next cycle and the divider restarts, so the next burst begins with a full high half.
- R6: A select change during a burst takes effect only at the end of the current low half. During a steady level it takes effect only at the next enable.
- R7: With `led_mode` high, `led_n` is 0 exactly in the cycles of a burst and changes on the same cycle edges as `rem_out`.
- R8: With `led_mode` low, `led_oe` is 0 and `led_n` stays 1 whatever the burst activity. `led_oe` follows `led_mode` one cycle later.
- R9: `cfg_sel` is loaded into the select register only on a cycle with `cfg_we` high. It is ignored otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock at twice the oscillator rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the carrier select register |
| cfg_sel | input | 3 | Carrier select code to write |
| tx_en | input | 1 | Transmit enable; gates the carrier onto `rem_out` |
| led_mode | input | 1 | 1 = indicator pin is an output, 0 = pin left as input |
| rem_out | output | 1 | Infrared transmit output, active high |
| led_n | output | 1 | Indicator drive value, active low |
| led_oe | output | 1 | Indicator output enable |

## Verification
Random bursts of random length are tried over all eight select codes with both indicator modes. Each output sample is compared against a half-period computed from the code. This separates the six divider ratios from each other and from the steady level, and it separates indicator output mode from input mode.

Directed patterns cover the remaining rules. One switches the ratio partway through a /8 burst, which shows that the change waits for the period boundary rather than cutting a half short. Another switches during a steady level, which shows that the change waits for the next enable. A further pattern drives `cfg_sel` without a write strobe to show that it is ignored. Disable-then-enable gaps show that each burst restarts on a full high half.

// File: rtl/ircg_pkg.sv
package ircg_pkg;

    localparam int SEL_W    = 3;
    localparam int MAX_HALF = 24;
    localparam int CNT_W    = $clog2(MAX_HALF);

    typedef enum logic [SEL_W-1:0] {
        CS_DIV1  = 3'd0,
        CS_DIV2  = 3'd1,
        CS_DIV8  = 3'd2,
        CS_DIV12 = 3'd3,
        CS_DIV16 = 3'd4,
        CS_DIV24 = 3'd5,
        CS_HIGH  = 3'd6,
        CS_RSVD  = 3'd7
    } csel_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MARK,
        ST_SPACE,
        ST_STEADY
    } cst_t;

    function automatic logic is_steady(input logic [SEL_W-1:0] s);
        return (s == CS_HIGH) || (s == CS_RSVD);
    endfunction

    // Half-period length minus one, in reference cycles.
    function automatic logic [CNT_W-1:0] half_m1(input logic [SEL_W-1:0] s);
        logic [CNT_W-1:0] r;
        case (s)
            CS_DIV1:  r = CNT_W'(0);
            CS_DIV2:  r = CNT_W'(1);
            CS_DIV8:  r = CNT_W'(7);
            CS_DIV12: r = CNT_W'(11);
            CS_DIV16: r = CNT_W'(15);
            CS_DIV24: r = CNT_W'(23);
            default:  r = CNT_W'(0);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ircg_cfg.sv
module ircg_cfg
    import ircg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] wdata,
    output logic [SEL_W-1:0] sel_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (we) begin
            sel_q <= wdata;
        end
    end

    // R9: a strobed write lands in the register
    p_sel_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (sel_q == $past(wdata)));

    // R9: without a strobe the register holds
    p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(sel_q));

endmodule

// File: rtl/ircg_fsm.sv
module ircg_fsm
    import ircg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic [SEL_W-1:0] sel_q,
    output logic             burst_d,
    output logic             mark_d
);

    cst_t             st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [SEL_W-1:0] act_q, act_d;

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        act_d = act_q;
        if (!tx_en) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    act_d = sel_q;
                    cnt_d = half_m1(sel_q);
                    st_d  = is_steady(sel_q) ? ST_STEADY : ST_MARK;
                end
                ST_MARK: begin
                    if (cnt_q == '0) begin
                        st_d  = ST_SPACE;
                        cnt_d = half_m1(act_q);
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                ST_SPACE: begin
                    if (cnt_q == '0) begin
                        act_d = sel_q;
                        cnt_d = half_m1(sel_q);
                        st_d  = is_steady(sel_q) ? ST_STEADY : ST_MARK;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                ST_STEADY: begin
                    st_d = ST_STEADY;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            act_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            act_q <= act_d;
        end
    end

    assign burst_d = (st_d != ST_IDLE);
    assign mark_d  = (st_d == ST_MARK) || (st_d == ST_STEADY);

    // R5: disable always returns the machine to IDLE
    p_disable_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (st_q == ST_IDLE));

    // R3: steady level persists while enabled
    p_steady_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STEADY && tx_en) |=> (st_q == ST_STEADY));

    // R6: ratio in use only changes at a period boundary
    p_ratio_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && (st_q == ST_MARK || (st_q == ST_SPACE && cnt_q != '0)))
        |=> $stable(act_q));

    // R2: half-period counter never exceeds the longest half
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_HALF - 1));

endmodule

// File: rtl/ircg_out.sv
module ircg_out (
    input  logic clk,
    input  logic rst_n,
    input  logic burst_d,
    input  logic mark_d,
    input  logic led_mode,
    output logic rem_q,
    output logic led_n_q,
    output logic led_oe_q
);

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q    <= 1'b0;
            led_n_q  <= 1'b1;
            led_oe_q <= 1'b0;
        end else begin
            rem_q    <= mark_d;
            led_n_q  <= !(burst_d && led_mode);
            led_oe_q <= led_mode;
        end
    end

    // R8: input mode leaves the indicator released
    p_led_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !led_mode |=> (led_n_q && !led_oe_q));

    // R7: indicator is low whenever the carrier is high in output mode
    p_led_follows_rem_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (led_oe_q && rem_q) |-> !led_n_q);

endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
    import ircg_pkg::*;
(
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic             tx_en,
    input  logic             led_mode,
    output logic             rem_out,
    output logic             led_n,
    output logic             led_oe
);

    logic [SEL_W-1:0] sel_q;
    logic             burst_d;
    logic             mark_d;

    ircg_cfg u_cfg (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_sel),
        .sel_q (sel_q)
    );

    ircg_fsm u_fsm (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .tx_en   (tx_en),
        .sel_q   (sel_q),
        .burst_d (burst_d),
        .mark_d  (mark_d)
    );

    ircg_out u_out (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .burst_d  (burst_d),
        .mark_d   (mark_d),
        .led_mode (led_mode),
        .rem_q    (rem_out),
        .led_n_q  (led_n),
        .led_oe_q (led_oe)
    );

    // R5: carrier output is dark the cycle after disable
    p_rem_dark_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !tx_en |=> !rem_out);

endmodule

// File: tb/ir_carrier_gen_tb.sv
module ir_carrier_gen_tb;

    logic       clk_ref = 1'b0;
    logic       rst_n   = 1'b0;
    logic       cfg_we  = 1'b0;
    logic [2:0] cfg_sel = 3'd0;
    logic       tx_en   = 1'b0;
    logic       led_mode = 1'b0;
    logic       rem_out, led_n, led_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk_ref = ~clk_ref;

    ir_carrier_gen u_dut (
        .clk_ref  (clk_ref),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .tx_en    (tx_en),
        .led_mode (led_mode),
        .rem_out  (rem_out),
        .led_n    (led_n),
        .led_oe   (led_oe)
    );

    function automatic int half_of(input logic [2:0] s);
        case (s)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 8;
            3'd3: return 12;
            3'd4: return 16;
            3'd5: return 24;
            default: return 0;
        endcase
    endfunction

    // k = samples since the burst started (0 = first high sample)
    function automatic logic exp_rem(input logic [2:0] s, input int k);
        int h;
        h = half_of(s);
        if (h == 0) return 1'b1;
        return ((k / h) % 2) == 0;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%0b expected=%0b", req, $time, act, exp);
        end
    endtask

    task automatic write_sel(input logic [2:0] s);
        cfg_we = 1'b1; cfg_sel = s;
        @(negedge clk_ref);
        cfg_we = 1'b0;
    endtask

    task automatic finish_burst();
        tx_en = 1'b0;
        @(negedge clk_ref);
        check("R5 rem after disable", rem_out, 1'b0);
        check("R7 led after disable", led_n, 1'b1);
    endtask

    task automatic run_burst(input logic [2:0] s, input int len, input logic mode);
        led_mode = mode;
        write_sel(s);
        tx_en = 1'b1;
        for (int k = 0; k < len; k++) begin
            @(negedge clk_ref);
            if (s >= 3'd6) check("R3 steady level", rem_out, exp_rem(s, k));
            else if (k == 0) check("R4 burst start", rem_out, 1'b1);
            else check("R2 carrier ratio", rem_out, exp_rem(s, k));
            check(mode ? "R7 led low in burst" : "R8 led idle in input mode",
                  led_n, !mode);
            check("R8 led_oe", led_oe, mode);
        end
        finish_burst();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk_ref);
        // R1: reset state
        check("R1 rem reset", rem_out, 1'b0);
        check("R1 led_n reset", led_n, 1'b1);
        check("R1 led_oe reset", led_oe, 1'b0);
        rst_n = 1'b1;
        // R1: select register resets to 000 -> undivided carrier
        led_mode = 1'b1;
        tx_en = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk_ref);
            check("R1 default select", rem_out, exp_rem(3'd0, k));
        end
        finish_burst();

        // Directed: every code once
        for (int s = 0; s < 8; s++) run_burst(3'(s), 60, 1'b1);

        // R8: input mode leaves indicator released
        run_burst(3'd1, 12, 1'b0);

        // R6: change /8 -> undivided during burst, waits for period boundary
        led_mode = 1'b1;
        write_sel(3'd2);
        tx_en = 1'b1;
        for (int k = 0; k < 32; k++) begin
            @(negedge clk_ref);
            if (k < 16) check("R6 old ratio kept", rem_out, exp_rem(3'd2, k));
            else        check("R6 new ratio at boundary", rem_out, exp_rem(3'd0, k - 16));
            cfg_we = (k == 3);
            cfg_sel = 3'd0;
        end
        cfg_we = 1'b0;
        finish_burst();

        // R6: change during steady waits for next enable
        write_sel(3'd6);
        tx_en = 1'b1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk_ref);
            check("R6 steady unaffected by write", rem_out, 1'b1);
            cfg_we = (k == 2);
            cfg_sel = 3'd1;
        end
        cfg_we = 1'b0;
        finish_burst();
        tx_en = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk_ref);
            check("R6 new ratio at next enable", rem_out, exp_rem(3'd1, k));
        end
        finish_burst();

        // R9: cfg_sel without strobe is ignored (register still holds 001)
        cfg_sel = 3'd5;
        @(negedge clk_ref);
        tx_en = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk_ref);
            check("R9 unstrobed write ignored", rem_out, exp_rem(3'd1, k));
        end
        finish_burst();

        // Random bursts
        for (int t = 0; t < 40; t++) begin
            logic [2:0] s;
            int len;
            logic m;
            s   = 3'($urandom % 8);
            len = 3 + int'($urandom % 70);
            m   = ($urandom % 4) != 0;
            run_burst(s, len, m);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule